// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. The operand width is cut into equal slices (four slices of four bits by default). Inside each slice, every bit forms its own generate and propagate terms. Each internal carry is computed directly from those terms and the slice carry-in, as a full sum of products, so no carry passes from bit to bit. Each slice also reports one group propagate and one group generate term.

A second-level lookahead unit takes the slice group terms and the adder carry-in. It forms, in the same expanded way, the carry into every slice and the final carry-out. The carry path is therefore two lookahead levels deep and does not grow with the width as a ripple chain would.

The block sits between registers in a datapath where a fixed 16-bit add with carry-in and carry-out has to fit in one cycle. If the width is not a multiple of the slice width, elaboration stops. A single-slice configuration omits the second-level unit.

Top module: `cla2_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `a_in + b_in + c_in`, taken as unsigned integers, for every operand pattern.
- R2: `c_out` equals bit WIDTH (the 17th bit at the default width) of `a_in + b_in + c_in`.
- R3: For bit i, the carry out of the bit is 1 when both operand bits are 1, or when exactly one is 1 and the carry into the bit is 1.
- R4: A slice whose operands alone overflow its four bits passes a carry of 1 into the next slice, whatever the carry into the slice.
- R5: A slice whose operand bits differ in every position passes its incoming carry unchanged to the next slice; a carry-in of 1 with `a_in` = 0xFFFF and `b_in` = 0 gives sum 0x0000 and carry-out 1.
- R6: With every bit position propagating and `c_in` = 0, no carry appears: 0xFFFF + 0x0000 + 0 gives 0xFFFF with carry-out 0.
- R7: Slice boundaries sit at bits 4, 8 and 12; a carry out of bits [3:0], [7:4] or [11:8] lands in the lowest bit of the next slice (for example 0x000F + 0x0001 = 0x0010).
- R8: The outputs are a pure function of the present inputs, with no clock and no state. A new input value is reflected without any clock edge, and inputs applied earlier have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH (16) | First operand |
| b_in | input | WIDTH (16) | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum, modulo 2^WIDTH |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The bench sweeps every operand pair and carry-in of each slice in turn. All the other slices are held at full propagate, so any carry that a slice makes or lets through is visible at `c_out` and in the upper sum bits. A wrong group generate term would lose carries such as 0x0080 + 0x0080. A wrong group propagate term, or a carry-in taken from the wrong slice, would corrupt the 0x0FFF + 1 style boundary crossings or the final carry-out. Random operand pairs, plus the all-ones cases with the carry-in at 0 and at 1, catch a missing product term in the expanded carry equations, which would show up only for particular runs of propagating bits.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
   parameter int CLA2_DEF_WIDTH = 16;
   parameter int CLA2_DEF_SLICE = 4;

   typedef struct packed {
      logic prop;
      logic gen;
   } cla2_pg_t;
endpackage

// File: rtl/cla2_carry_net.sv
module cla2_carry_net #(
   parameter int N = 4
) (
   input  logic [N-1:0] p_i,
   input  logic [N-1:0] g_i,
   input  logic         c0_i,
   output logic [N:0]   c_o
);
   initial begin
      if (N < 1) $error("cla2_carry_net: N must be at least 1");
   end

   always_comb begin
      logic acc;
      logic term;
      c_o[0] = c0_i;
      for (int k = 1; k <= N; k++) begin
         term = c0_i;
         for (int m = 0; m < k; m++) term = term & p_i[m];
         acc = term;
         for (int j = 0; j < k; j++) begin
            term = g_i[j];
            for (int m = j + 1; m < k; m++) term = term & p_i[m];
            acc = acc | term;
         end
         c_o[k] = acc;
      end
   end

   always_comb begin
      for (int k = 1; k <= N; k++) begin
         AST_CARRY_RECUR: assert (c_o[k] == (g_i[k-1] | (p_i[k-1] & c_o[k-1]))); // R3
      end
   end
endmodule

// File: rtl/cla2_group_pg.sv
module cla2_group_pg #(
   parameter int N = 4
) (
   input  logic [N-1:0] p_i,
   input  logic [N-1:0] g_i,
   output logic         gp_o,
   output logic         gg_o
);
   always_comb begin
      logic term;
      gp_o = &p_i;
      gg_o = 1'b0;
      for (int j = 0; j < N; j++) begin
         term = g_i[j];
         for (int m = j + 1; m < N; m++) term = term & p_i[m];
         gg_o = gg_o | term;
      end
   end
endmodule

// File: rtl/cla2_slice.sv
module cla2_slice
   import cla2_pkg::*;
#(
   parameter int SW = 4
) (
   input  logic [SW-1:0] opa_i,
   input  logic [SW-1:0] opb_i,
   input  logic          cin_i,
   output logic [SW-1:0] sum_o,
   output cla2_pg_t      grp_o
);
   logic [SW-1:0] bit_p;
   logic [SW-1:0] bit_g;
   logic [SW:0]   carry;

   genvar gi;
   generate
      for (gi = 0; gi < SW; gi++) begin : g_bit
         assign bit_p[gi] = opa_i[gi] ^ opb_i[gi];
         assign bit_g[gi] = opa_i[gi] & opb_i[gi];
         assign sum_o[gi] = bit_p[gi] ^ carry[gi];
      end
   endgenerate

   cla2_carry_net #(.N(SW)) i_carry (
      .p_i  (bit_p),
      .g_i  (bit_g),
      .c0_i (cin_i),
      .c_o  (carry)
   );

   cla2_group_pg #(.N(SW)) i_grp (
      .p_i  (bit_p),
      .g_i  (bit_g),
      .gp_o (grp_o.prop),
      .gg_o (grp_o.gen)
   );

   always_comb begin
      AST_GROUP_EXCL: assert (!(grp_o.prop && grp_o.gen)); // R4
      AST_SLICE_SUM: assert ({grp_o.gen | (grp_o.prop & cin_i), sum_o} == ({1'b0, opa_i} + {1'b0, opb_i} + {{SW{1'b0}}, cin_i})); // R5
   end
endmodule

// File: rtl/cla2_lookahead.sv
module cla2_lookahead
   import cla2_pkg::*;
#(
   parameter int NG = 4
) (
   input  cla2_pg_t [NG-1:0] grp_i,
   input  logic              c0_i,
   output logic [NG-1:0]     slice_cin_o,
   output logic              cout_o
);
   logic [NG-1:0] gp;
   logic [NG-1:0] gg;
   logic [NG:0]   c;

   genvar gi;
   generate
      for (gi = 0; gi < NG; gi++) begin : g_unpack
         assign gp[gi] = grp_i[gi].prop;
         assign gg[gi] = grp_i[gi].gen;
      end
   endgenerate

   cla2_carry_net #(.N(NG)) i_net (
      .p_i  (gp),
      .g_i  (gg),
      .c0_i (c0_i),
      .c_o  (c)
   );

   assign slice_cin_o = c[NG-1:0];
   assign cout_o      = c[NG];

   always_comb begin
      for (int k = 0; k < NG; k++) begin
         AST_GROUP_GEN_CARRY: assert (!gg[k] || ((k == NG - 1) ? cout_o : slice_cin_o[k+1])); // R4
      end
   end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
   import cla2_pkg::*;
#(
   parameter int WIDTH   = CLA2_DEF_WIDTH,
   parameter int SLICE_W = CLA2_DEF_SLICE
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             c_out
);
   localparam int NSLICE = WIDTH / SLICE_W;

   initial begin
      if (SLICE_W < 1) $error("cla2_adder: SLICE_W must be at least 1");
      if (WIDTH % SLICE_W != 0) $error("cla2_adder: WIDTH must be a multiple of SLICE_W");
   end

   cla2_pg_t [NSLICE-1:0] grp;
   logic [NSLICE-1:0]     slice_cin;

   genvar gs;
   generate
      for (gs = 0; gs < NSLICE; gs++) begin : g_slice
         cla2_slice #(.SW(SLICE_W)) i_slice (
            .opa_i (a_in[gs*SLICE_W +: SLICE_W]),
            .opb_i (b_in[gs*SLICE_W +: SLICE_W]),
            .cin_i (slice_cin[gs]),
            .sum_o (sum_out[gs*SLICE_W +: SLICE_W]),
            .grp_o (grp[gs])
         );
      end

      if (NSLICE == 1) begin : g_single
         assign slice_cin[0] = c_in;
         assign c_out        = grp[0].gen | (grp[0].prop & c_in);
      end else begin : g_two_level
         cla2_lookahead #(.NG(NSLICE)) i_lcu (
            .grp_i       (grp),
            .c0_i        (c_in),
            .slice_cin_o (slice_cin),
            .cout_o      (c_out)
         );
      end
   endgenerate

   always_comb begin
      AST_SUM_MATCH: assert (sum_out == (a_in + b_in + {{(WIDTH-1){1'b0}}, c_in})); // R1
      AST_COUT_MATCH: assert (c_out == (({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}) >> WIDTH)); // R2
   end
endmodule

// File: tb/test_cla2_adder.sv
module test_cla2_adder;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         c_in = 1'b0;
   logic [W-1:0] sum_out;
   logic         c_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   cla2_adder i_cla2_adder (
      .a_in    (a_in),
      .b_in    (b_in),
      .c_in    (c_in),
      .sum_out (sum_out),
      .c_out   (c_out)
   );

   task automatic check_add(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic ci, input string req);
      logic [W:0] exp;
      @(negedge clk);
      a_in = a;
      b_in = b;
      c_in = ci;
      #2;
      exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      n_checks++;
      if ({c_out, sum_out} !== exp) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
                  req, a, b, ci, c_out, sum_out, exp[W], exp[W-1:0]);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      // R8: initial zero inputs give zero outputs
      check_add(16'h0000, 16'h0000, 1'b0, "R8 zero");
      // R5: full propagate with carry-in ripples to carry-out
      check_add(16'hFFFF, 16'h0000, 1'b1, "R5 all-propagate cin=1");
      // R6: full propagate without carry-in gives no carry
      check_add(16'hFFFF, 16'h0000, 1'b0, "R6 all-propagate cin=0");
      check_add(16'h5555, 16'hAAAA, 1'b0, "R6 alternating propagate");
      check_add(16'h5555, 16'hAAAA, 1'b1, "R5 alternating propagate cin=1");
      // R2: all-ones generate
      check_add(16'hFFFF, 16'hFFFF, 1'b1, "R2 all-ones cin=1");
      check_add(16'hFFFF, 16'hFFFF, 1'b0, "R2 all-ones cin=0");
      // R7: slice boundary crossings
      check_add(16'h000F, 16'h0001, 1'b0, "R7 boundary 4");
      check_add(16'h00FF, 16'h0001, 1'b0, "R7 boundary 8");
      check_add(16'h0FFF, 16'h0000, 1'b1, "R7 boundary 12");
      // R4: slice generates regardless of carry-in
      check_add(16'h0080, 16'h0080, 1'b0, "R4 group generate");
      check_add(16'h8000, 16'h8000, 1'b1, "R4 top group generate");
      // R3: single bit generate and propagate
      check_add(16'h0001, 16'h0001, 1'b0, "R3 bit generate");
      check_add(16'h0001, 16'h0000, 1'b1, "R3 bit propagate");
      // R4/R5: per-slice exhaustive sweep, other slices propagating
      for (int s = 0; s < W / 4; s++) begin
         for (int na = 0; na < 16; na++) begin
            for (int nb = 0; nb < 16; nb++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  logic [W-1:0] bga;
                  logic [W-1:0] bgb;
                  bga = 16'hFFFF & ~(16'hF << (4 * s));
                  bgb = 16'h0000;
                  check_add(bga | (W'(na) << (4 * s)), bgb | (W'(nb) << (4 * s)),
                            ci[0], "R4/R5 slice sweep");
               end
            end
         end
      end
      // R1/R2: random operands
      for (int i = 0; i < 3000; i++) begin
         ra = W'($urandom);
         rb = W'($urandom);
         check_add(ra, rb, i[0], "R1/R2 random");
      end
      // R8: result depends only on present inputs, no clock between changes
      @(negedge clk);
      a_in = 16'h1234; b_in = 16'h4321; c_in = 1'b1;
      #1;
      a_in = 16'h0F0F; b_in = 16'h00F1; c_in = 1'b0;
      #1;
      n_checks++;
      if ({c_out, sum_out} !== 17'h01000) begin
         n_fail++;
         $display("FAIL R8 no-edge update: got %h expected %h", {c_out, sum_out}, 17'h01000);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule